// File: doc/BRIEF.md
# Stepped receive automatic gain control

This block drives the 3-bit gain code of an analog receive amplifier. It looks at the signed two's-complement samples that leave the receive A/D converter and adds up their magnitudes. It then moves the amplifier one 6 dB step at a time so that the summed magnitude stays inside a window that software places around a chosen fraction of full scale. The window is given as a lower and an upper threshold on that sum.

A chip-rate strobe divides time into chip periods, and the periods alternate between measuring and updating. During a measurement period the controller gathers magnitudes at one fixed gain. The strobe that closes the period makes the gain decision and holds it in a pending register. The decision is applied at the strobe that opens the next measurement period. As a result, every measurement is taken under a single gain setting. The measurement periods all have the same length, so the sum over one period stands for the average level. The sum itself is compared with the thresholds and no divider is needed.

Top module: `rx_gain_ctrl`

## Requirements
- R1: After reset the gain code is 7 (the highest gain), the accumulator is zero and the controller is in the update phase, so the first chip strobe opens a measurement period.
- R2: The accumulator adds the magnitude of a sample only when the sample is valid, the controller is in the measurement phase and the chip strobe is low. Samples that arrive during the update phase, or in a strobe cycle, have no effect on the decision.
- R3: A sample's magnitude is its two's-complement absolute value. The most negative code (0x800 at 12 bits) counts as 2048.
- R4: The accumulator saturates at all ones (2^20-1 with the default widths) and never wraps.
- R5: Every chip strobe toggles the phase between measurement and update.
- R6: At the strobe that closes a measurement period, the decision compares the sum with the thresholds. If the sum is greater than the upper threshold, the code goes down by one. Otherwise, if the sum is less than the lower threshold, the code goes up by one. In all other cases the code holds. The upper-threshold test has priority when both tests are true.
- R7: The gain code saturates at 0 and at 7 and never wraps.
- R8: The gain code changes only at the clock edge that samples the strobe opening a measurement period. It then takes the decision made at the end of the previous measurement period.
- R9: The thresholds are used only in the cycle of the strobe that closes a measurement period. Changing them at any other time has no effect on the decision already made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| smp_vld | input | 1 | Sample valid |
| smp_data | input | 12 | Signed converter sample |
| chip_stb | input | 1 | One-cycle chip boundary strobe |
| thr_hi | input | 20 | Upper window threshold on the magnitude sum |
| thr_lo | input | 20 | Lower window threshold on the magnitude sum |
| gain_code | output | 3 | Amplifier gain step, 7 is the highest gain |

## Verification
A gain decision is taken at the edge that samples the strobe closing a measurement period. It appears on gain_code just after the edge that samples the next strobe, one full update period later. A sample changes the accumulator one edge after it is presented. The bench drives each input half a cycle before an edge and updates its own model one step after that edge. It compares gain_code with the model every cycle. The directed cases check the hand-derived code just after the opening strobe of the following measurement period.

// File: rtl/rxagc_pkg.sv
package rxagc_pkg;
  typedef enum logic {
    PH_UPD  = 1'b0,
    PH_MEAS = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/rxagc_mag_acc.sv
module rxagc_mag_acc #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] data,
  output logic [ACC_W-1:0]    acc_q
);
  localparam int SUM_W = ACC_W + 1;

  logic [SAMPLE_W-1:0] mag;
  logic [SUM_W-1:0]    sum;
  logic [ACC_W-1:0]    acc_d;

  // two's-complement magnitude; the most negative code maps onto its unsigned value
  always_comb begin
    if (data[SAMPLE_W-1]) mag = ~data + 1'b1;
    else                  mag = data;
  end

  always_comb begin
    sum = {1'b0, acc_q} + SUM_W'(mag);
    if (clr)                acc_d = '0;
    else if (!en)           acc_d = acc_q;
    else if (sum[ACC_W])    acc_d = '1;
    else                    acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (acc_q >= $past(acc_q)));

  // R4
  acc_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (&acc_q)) |=> (&acc_q));

  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/rxagc_step.sv
module rxagc_step #(
  parameter int GAIN_W = 3,
  parameter int ACC_W  = 20
) (
  input  logic [GAIN_W-1:0] gain_in,
  input  logic [ACC_W-1:0]  level,
  input  logic [ACC_W-1:0]  hi,
  input  logic [ACC_W-1:0]  lo,
  output rxagc_pkg::step_e  dir,
  output logic [GAIN_W-1:0] gain_next
);
  import rxagc_pkg::*;

  localparam logic [GAIN_W-1:0] GMAX = '1;

  always_comb begin
    if (level > hi)      dir = STEP_DOWN;
    else if (level < lo) dir = STEP_UP;
    else                 dir = STEP_HOLD;
  end

  always_comb begin
    gain_next = gain_in;
    case (dir)
      STEP_DOWN: if (gain_in != '0)  gain_next = gain_in - 1'b1;
      STEP_UP:   if (gain_in != GMAX) gain_next = gain_in + 1'b1;
      default:   gain_next = gain_in;
    endcase
  end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20,
  parameter int GAIN_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                chip_stb,
  input  logic [ACC_W-1:0]    thr_hi,
  input  logic [ACC_W-1:0]    thr_lo,
  output logic [GAIN_W-1:0]   gain_code
);
  import rxagc_pkg::*;

  localparam logic [GAIN_W-1:0] GMAX = '1;

  phase_e            phase_q, phase_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [GAIN_W-1:0] pend_q, pend_d;
  logic [GAIN_W-1:0] step_gain;
  logic [ACC_W-1:0]  acc;
  step_e             step_dir;
  logic              meas_start, meas_end, acc_en;

  assign meas_start = chip_stb && (phase_q == PH_UPD);
  assign meas_end   = chip_stb && (phase_q == PH_MEAS);
  assign acc_en     = smp_vld && (phase_q == PH_MEAS) && !chip_stb;

  rxagc_mag_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (meas_start),
    .en    (acc_en),
    .data  (smp_data),
    .acc_q (acc)
  );

  rxagc_step #(.GAIN_W(GAIN_W), .ACC_W(ACC_W)) u_step (
    .gain_in   (gain_q),
    .level     (acc),
    .hi        (thr_hi),
    .lo        (thr_lo),
    .dir       (step_dir),
    .gain_next (step_gain)
  );

  always_comb begin
    phase_d = phase_q;
    pend_d  = pend_q;
    gain_d  = gain_q;
    if (chip_stb) phase_d = (phase_q == PH_MEAS) ? PH_UPD : PH_MEAS;
    if (meas_end)   pend_d = step_gain;
    if (meas_start) gain_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_UPD;
      pend_q  <= GMAX;
      gain_q  <= GMAX;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      gain_q  <= gain_d;
    end
  end

  assign gain_code = gain_q;

  // R5
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb |=> (phase_q != $past(phase_q)));

  // R8
  gain_move_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_start |=> (gain_q == $past(gain_q)));

  // R7
  pend_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_end |=> ((pend_q == gain_q) || (pend_q == gain_q + 1'b1 && gain_q != GMAX)
                  || (pend_q == gain_q - 1'b1 && gain_q != '0)));

  // R6
  down_when_loud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_end && (acc > thr_hi) && (gain_q != '0)) |=> (pend_q == $past(gain_q) - 1'b1));
endmodule

// File: tb/tb_rx_gain_ctrl.sv
module tb_rx_gain_ctrl;
  localparam int SW = 12;
  localparam int AW = 20;
  localparam int GW = 3;
  localparam longint AMAX = (64'd1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_vld;
  logic [SW-1:0] smp_data;
  logic          chip_stb;
  logic [AW-1:0] thr_hi, thr_lo;
  logic [GW-1:0] gain_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit     m_ph;
  longint m_acc;
  int     m_gain, m_pend;

  always #2.5 clk = ~clk;

  rx_gain_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .chip_stb(chip_stb), .thr_hi(thr_hi), .thr_lo(thr_lo), .gain_code(gain_code)
  );

  function automatic int mag_of(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int step_of(int g, longint s, longint hi, longint lo);
    if (s > hi) return (g > 0) ? g - 1 : 0;
    if (s < lo) return (g < 7) ? g + 1 : 7;
    return g;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: gain_code=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(bit v, int d, bit s);
    bit st, en_;
    longint t;
    @(negedge clk);
    smp_vld = v; smp_data = SW'(d); chip_stb = s;
    @(posedge clk);
    #1;
    st = s && !m_ph;
    en_ = s && m_ph;
    if (en_) m_pend = step_of(m_gain, m_acc, longint'(thr_hi), longint'(thr_lo));
    if (st) begin
      m_gain = m_pend;
      m_acc = 0;
    end else if (m_ph && !s && v) begin
      t = m_acc + mag_of(d);
      m_acc = (t > AMAX) ? AMAX : t;
    end
    if (s) m_ph = !m_ph;
    check("R8", int'(gain_code), m_gain);
  endtask

  // strobe opening a measurement period, with a loud sample that must be dropped (R2)
  task automatic open_meas();
    cyc(1'b1, -2000, 1'b1);
  endtask

  task automatic close_meas();
    cyc(1'b1, 2047, 1'b1);
  endtask

  task automatic samples(int n, int amp, bit neg);
    for (int i = 0; i < n; i++) cyc(1'b1, neg ? -amp : amp, 1'b0);
  endtask

  task automatic junk(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, (i % 2) ? 2047 : -2048, 1'b0);
  endtask

  task automatic rnd_samples(int n, int amax);
    for (int i = 0; i < n; i++) begin
      int a;
      a = $urandom_range(amax, 0);
      cyc(($urandom_range(3, 0) != 0), ($urandom_range(1, 0) != 0) ? -a : a, 1'b0);
    end
  endtask

  // one full measure/update round with a fixed sample value, then open the next period
  task automatic round(int n, int amp, bit neg);
    samples(n, amp, neg);
    close_meas();
    junk(4);
    open_meas();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: gain_code=%0d expected=finish", gain_code);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; chip_stb = 1'b0;
    thr_hi = 20'd4000; thr_lo = 20'd1000;
    m_ph = 1'b0; m_acc = 0; m_gain = 7; m_pend = 7;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(gain_code), 7);
    @(negedge clk); rst_n = 1'b1;

    // R1: first strobe opens measurement; silent chip -> up request saturates at 7 (R7)
    open_meas();
    check("R1", int'(gain_code), 7);
    round(10, 0, 1'b0);
    check("R7", int'(gain_code), 7);

    // R3: ten samples of the most negative code sum to 20480 > 20479
    thr_hi = 20'd20479; thr_lo = 20'd100;
    round(10, 2048, 1'b1);
    check("R3", int'(gain_code), 6);

    // R6: loud chips walk the code down one step each
    thr_hi = 20'd4000; thr_lo = 20'd1000;
    for (int k = 5; k >= 0; k--) begin
      round(10, 1000, 1'b0);
      check("R6", int'(gain_code), k);
    end
    round(10, 1000, 1'b0);
    check("R7", int'(gain_code), 0);

    // R4: 600 x 2047 saturates the sum; a wrapped sum would fall below lo and raise the code
    thr_hi = 20'hFFFFF; thr_lo = 20'hFFFFE;
    round(600, 2047, 1'b0);
    check("R4", int'(gain_code), 0);

    // R6: quiet chip raises the code
    thr_hi = 20'd4000; thr_lo = 20'd1000;
    round(10, 10, 1'b0);
    check("R6", int'(gain_code), 1);

    // R2: sum 500 inside [400,600] holds, despite loud samples on strobes and in update phase
    thr_hi = 20'd600; thr_lo = 20'd400;
    round(5, 100, 1'b0);
    check("R2", int'(gain_code), 1);

    // R6: both tests true (sum 500 > hi 400, < lo 600) -> down has priority
    thr_hi = 20'd400; thr_lo = 20'd600;
    round(5, 100, 1'b1);
    check("R6", int'(gain_code), 0);

    // R9: quiet chip decides up; thresholds moved during update must not alter it
    thr_hi = 20'd4000; thr_lo = 20'd1000;
    samples(5, 10, 1'b0);
    close_meas();
    thr_hi = 20'd0; thr_lo = 20'd0;
    junk(4);
    open_meas();
    check("R9", int'(gain_code), 1);
    // R9: thresholds set mid-measurement apply only as sampled at the closing strobe
    thr_hi = 20'd0;
    samples(5, 100, 1'b0);
    thr_hi = 20'd600; thr_lo = 20'd400;
    close_meas();
    junk(3);
    open_meas();
    check("R9", int'(gain_code), 1);

    // R5: back-to-back strobes still alternate phases; per-cycle model compare covers it
    close_meas();
    open_meas();
    close_meas();
    open_meas();

    // random rounds against the model (R2, R6, R8)
    for (int r = 0; r < 300; r++) begin
      int lo_v, n;
      n = $urandom_range(30, 6);
      lo_v = $urandom_range(20000, 0);
      thr_lo = AW'(lo_v);
      thr_hi = AW'(lo_v + $urandom_range(30000, 0));
      rnd_samples(n, $urandom_range(2047, 0));
      close_meas();
      rnd_samples($urandom_range(20, 1), 2047);
      open_meas();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule